// File: doc/BRIEF.md
# Memory card host interrupt status register

This block is the 8-bit interrupt status register of a memory card host controller. It sits on a simple register bus with a select, a read strobe and a write strobe. It holds two sticky event flags and one live status bit, and it drives a single active-high interrupt line.

The card-change flag records any level change of the raw card presence signal, on insertion or removal, while its enable is set. The raw signal first passes through a synchroniser. The FIFO-ready flag records that DMA is enabled with its enable set while the FIFO fill level does not yet satisfy the DMA request rule. A third, read-only bit mirrors that FIFO comparison.

Each sticky flag is a three-state machine:
- `FL_IDLE`: the flag is clear.
- `FL_PEND`: the flag is set and has not yet been read.
- `FL_ARMED`: the flag is set and has been read as 1.

The transitions are:
- `FL_IDLE` -> `FL_PEND` on a set event.
- `FL_PEND` -> `FL_ARMED` on a register read.
- `FL_ARMED` -> `FL_IDLE` on a write of 0 to the flag's bit.
- `FL_ARMED` -> `FL_PEND` on a new set event.
- `FL_PEND` -> `FL_PEND` on a set event.

A set event takes priority over every other transition. Software therefore clears a flag by reading it and then writing 0 to it.

Top module: `mcard_irq_stat`

## Requirements
- R1: The register is 8 bits wide and resets to 0x02. Bits 7 to 3 always read as 0, and writes to them have no effect.
- R2: Bit 2 is the card-change flag. When `cd_irq_en` is 1 and `card_id_raw` changes level in either direction, bit 2 becomes 1 no later than the third rising clock edge after the change.
- R3: While `cd_irq_en` is 0, a level change of `card_id_raw` never sets bit 2.
- R4: Bit 1 is read-only and resets to 1. It is registered from the FIFO comparison: on the edge after `fifo_meets` is sampled, bit 1 reads 0 if `fifo_meets` was 1, and 1 if it was 0.
- R5: Bit 0 is the FIFO-ready flag. It is 1 on the edge after a cycle in which `frdy_irq_en`, `dma_en` and not `fifo_meets` all hold. No other input combination sets it.
- R6: A flag clears only when a bus write carries 0 in the flag's bit position and the flag was read as 1 by an earlier bus read since it last set. A write of 0 without such a read leaves the flag at 1.
- R7: Writing 1 to bit 0 or bit 2 never changes that flag.
- R8: While the FIFO-ready set condition keeps holding, bit 0 comes back to 1 after every read-and-clear sequence. Once `frdy_irq_en` is dropped, the same sequence leaves bit 0 at 0.
- R9: If a set event and a valid clear fall in the same cycle, the flag stays 1.
- R10: `irq` resets to 0. It equals the OR of bit 2 and bit 0 as they stood one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_sel | input | 1 | Register select |
| reg_rd | input | 1 | Read strobe, qualified by `reg_sel` |
| reg_wr | input | 1 | Write strobe, qualified by `reg_sel` |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Current register value, always driven |
| card_id_raw | input | 1 | Asynchronous card presence signal |
| cd_irq_en | input | 1 | Enable for the card-change flag |
| frdy_irq_en | input | 1 | Enable for the FIFO-ready flag |
| dma_en | input | 1 | DMA enable |
| fifo_meets | input | 1 | 1 when the remaining FIFO data satisfies the DMA request rule |
| irq | output | 1 | Registered interrupt request, active high |

## Verification
Some properties are checked on every cycle:
- The reserved bits stay at zero.
- The threshold bit tracks the comparator with one cycle of delay.
- The FIFO-ready set condition always yields a set flag on the next cycle, which also covers a set that collides with a clear.
- Any falling flag is preceded by a bus write of 0 to its bit.
- `irq` follows the flags one cycle later.

Other behaviour needs the bench's scenarios:
- That a write of 0 is refused unless a read came first.
- That the flag re-asserts until its enable is dropped.
- That the card-change flag responds to both edges only when enabled.

The bench also sweeps all eight combinations of the FIFO set inputs.

// File: rtl/cis_pkg.sv
package cis_pkg;
    typedef enum logic [1:0] {
        FL_IDLE  = 2'd0,
        FL_PEND  = 2'd1,
        FL_ARMED = 2'd2
    } flag_st_e;

    localparam int REG_W     = 8;
    localparam int NUM_FLAGS = 2;
    localparam int FR_BIT    = 0;
    localparam int THR_BIT   = 1;
    localparam int CD_BIT    = 2;
endpackage

// File: rtl/cis_sync_edge.sv
module cis_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic edge_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= async_i;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= 1'b0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    always_comb edge_o = chain_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/cis_flag_fsm.sv
module cis_flag_fsm
    import cis_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic rd_hit,
    input  logic wr_zero,
    output logic flag_o
);
    flag_st_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FL_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FL_IDLE: begin
                if (set_ev) st_d = FL_PEND;
            end
            FL_PEND: begin
                if (set_ev)      st_d = FL_PEND;
                else if (rd_hit) st_d = FL_ARMED;
            end
            FL_ARMED: begin
                if (set_ev)       st_d = FL_PEND;
                else if (wr_zero) st_d = FL_IDLE;
            end
            default: st_d = FL_IDLE;
        endcase
    end

    always_comb flag_o = (st_q != FL_IDLE);
endmodule

// File: rtl/mcard_irq_stat.sv
module mcard_irq_stat
    import cis_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_sel,
    input  logic             reg_rd,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             card_id_raw,
    input  logic             cd_irq_en,
    input  logic             frdy_irq_en,
    input  logic             dma_en,
    input  logic             fifo_meets,
    output logic             irq
);
    localparam int FLAG_POS [NUM_FLAGS] = '{FR_BIT, CD_BIT};

    logic                 card_edge;
    logic [NUM_FLAGS-1:0] set_ev;
    logic [NUM_FLAGS-1:0] flags;
    logic [REG_W-1:0]     zero_wr;
    logic                 rd_hit;
    logic                 thr_q;
    logic                 irq_q;

    cis_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (card_id_raw),
        .edge_o  (card_edge)
    );

    always_comb begin
        rd_hit    = reg_sel & reg_rd;
        zero_wr   = {REG_W{reg_sel & reg_wr}} & ~reg_wdata;
        set_ev[0] = frdy_irq_en & dma_en & ~fifo_meets;
        set_ev[1] = cd_irq_en & card_edge;
    end

    generate
        for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
            cis_flag_fsm u_fsm (
                .clk     (clk),
                .rst_n   (rst_n),
                .set_ev  (set_ev[g]),
                .rd_hit  (rd_hit),
                .wr_zero (zero_wr[FLAG_POS[g]]),
                .flag_o  (flags[g])
            );
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_q <= 1'b1;
            irq_q <= 1'b0;
        end else begin
            thr_q <= ~fifo_meets;
            irq_q <= |flags;
        end
    end

    always_comb begin
        reg_rdata          = '0;
        reg_rdata[FR_BIT]  = flags[0];
        reg_rdata[THR_BIT] = thr_q;
        reg_rdata[CD_BIT]  = flags[1];
        irq                = irq_q;
    end
endmodule

// File: rtl/mcard_irq_stat_chk.sv
module mcard_irq_stat_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_sel,
    input logic       reg_wr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       frdy_irq_en,
    input logic       dma_en,
    input logic       fifo_meets,
    input logic       irq
);
    logic warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) warm_q <= 1'b0;
        else        warm_q <= 1'b1;
    end

    p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[7:3] == 5'd0);

    p_thr_track_r4: assert property (@(posedge clk) disable iff (!rst_n || !warm_q)
        reg_rdata[1] == !$past(fifo_meets));

    // covers R5 and R9
    p_fr_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (frdy_irq_en && dma_en && !fifo_meets) |=> reg_rdata[0]);

    p_fr_clear_r6: assert property (@(posedge clk) disable iff (!rst_n || !warm_q)
        $fell(reg_rdata[0]) |-> $past(reg_sel && reg_wr && !reg_wdata[0]));

    p_cd_clear_r6: assert property (@(posedge clk) disable iff (!rst_n || !warm_q)
        $fell(reg_rdata[2]) |-> $past(reg_sel && reg_wr && !reg_wdata[2]));

    p_irq_or_r10: assert property (@(posedge clk) disable iff (!rst_n || !warm_q)
        irq == $past(reg_rdata[2] || reg_rdata[0]));
endmodule

bind mcard_irq_stat mcard_irq_stat_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_sel     (reg_sel),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .frdy_irq_en (frdy_irq_en),
    .dma_en      (dma_en),
    .fifo_meets  (fifo_meets),
    .irq         (irq)
);

// File: tb/sim_mcard_irq_stat.sv
module sim_mcard_irq_stat;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_sel = 1'b0, reg_rd = 1'b0, reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       card_id_raw = 1'b0, cd_irq_en = 1'b0, frdy_irq_en = 1'b0;
    logic       dma_en = 1'b0, fifo_meets = 1'b0;
    logic       irq;
    int         n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    mcard_irq_stat u0 (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .card_id_raw(card_id_raw),
        .cd_irq_en(cd_irq_en), .frdy_irq_en(frdy_irq_en), .dma_en(dma_en),
        .fifo_meets(fifo_meets), .irq(irq)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_read();
        reg_sel = 1'b1; reg_rd = 1'b1;
        tick();
        reg_sel = 1'b0; reg_rd = 1'b0;
    endtask

    task automatic bus_write(logic [7:0] d);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = d;
        tick();
        reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = 8'h00;
    endtask

    function automatic logic [7:0] expv(logic cd, logic thr, logic fr);
        return {5'd0, cd, thr, fr};
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset value", reg_rdata, 8'h02);
        chk("R10 reset irq", {7'd0, irq}, 8'h00);
        rst_n = 1'b1;
        tick();

        // R1 and R7: writes of all ones change nothing
        bus_write(8'hFF);
        chk("R1 R7 write ones", reg_rdata, 8'h02);

        // R4: threshold bit follows the comparator
        fifo_meets = 1'b1; tick();
        chk("R4 meets", reg_rdata, expv(0, 0, 0));
        fifo_meets = 1'b0; tick();
        chk("R4 not meets", reg_rdata, expv(0, 1, 0));

        // R5: sweep all eight set-input combinations
        for (int c = 0; c < 8; c++) begin
            frdy_irq_en = c[0]; dma_en = c[1]; fifo_meets = c[2];
            tick();
            chk("R5 sweep", reg_rdata, expv(0, ~c[2], c[0] & c[1] & ~c[2]));
            frdy_irq_en = 1'b0; dma_en = 1'b0; fifo_meets = 1'b0;
            bus_read(); bus_write(8'h00);
            chk("R6 sweep clear", reg_rdata, expv(0, 1, 0));
        end

        // R6: a write of 0 without a prior read keeps the flag set
        frdy_irq_en = 1'b1; dma_en = 1'b1; tick();
        frdy_irq_en = 1'b0; dma_en = 1'b0;
        bus_write(8'h00);
        chk("R6 unread write", reg_rdata, expv(0, 1, 1));
        chk("R10 irq high", {7'd0, irq}, 8'h01);
        bus_read();
        bus_write(8'h01);
        chk("R7 write one", reg_rdata, expv(0, 1, 1));
        bus_write(8'h00);
        chk("R6 read then clear", reg_rdata, expv(0, 1, 0));
        tick();
        chk("R10 irq low", {7'd0, irq}, 8'h00);

        // R8: the flag re-asserts while the condition persists
        frdy_irq_en = 1'b1; dma_en = 1'b1; tick();
        bus_read(); bus_write(8'h00);
        chk("R8 reassert", reg_rdata, expv(0, 1, 1));
        frdy_irq_en = 1'b0;
        bus_read(); bus_write(8'h00);
        chk("R8 enable dropped", reg_rdata, expv(0, 1, 0));
        dma_en = 1'b0;

        // R9: a set event in the same cycle as a valid clear wins
        frdy_irq_en = 1'b1; dma_en = 1'b1; tick();
        frdy_irq_en = 1'b0; bus_read();
        frdy_irq_en = 1'b1; bus_write(8'h00);
        chk("R9 set beats clear", reg_rdata, expv(0, 1, 1));
        frdy_irq_en = 1'b0; dma_en = 1'b0;
        bus_read(); bus_write(8'h00);

        // R3: a card change with the enable off
        card_id_raw = 1'b1;
        repeat (4) tick();
        chk("R3 disabled", reg_rdata, expv(0, 1, 0));

        // R2: falling and rising changes with the enable on
        cd_irq_en = 1'b1;
        card_id_raw = 1'b0;
        repeat (3) tick();
        chk("R2 falling", reg_rdata, expv(1, 1, 0));
        bus_read(); bus_write(8'h00);
        chk("R6 card clear", reg_rdata, expv(0, 1, 0));
        card_id_raw = 1'b1;
        repeat (3) tick();
        chk("R2 rising", reg_rdata, expv(1, 1, 0));
        tick();
        chk("R10 irq from card", {7'd0, irq}, 8'h01);
        bus_write(8'h00);
        chk("R6 card unread", reg_rdata, expv(1, 1, 0));
        bus_read(); bus_write(8'h00);
        chk("R6 card read clear", reg_rdata, expv(0, 1, 0));

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule